// File: doc/BRIEF.md
# Sticky Reset Cause Register

This block keeps a record of why the system went through reset. Each reset source delivers a one-cycle event pulse: the external reset pin, brown-out detection, watchdog 0, watchdog 1, a software reset request, and the hibernation-sequence reset. A main-oscillator failure is also a source, but it counts only when it really produced a reset. Every qualified event sets its own flag. The flags survive ordinary resets, so causes build up over time until software removes them.

A true power-on, signalled on a dedicated synchronous input, replaces the whole register with a value that has only the power-on flag set. Four of the sources (external pin, brown-out and the two watchdogs) each have a 2-bit behaviour field. When a field holds 2'b11, that source performs a simulated power-on. In that case the register clears all earlier causes and keeps only the flags raised in that cycle; the power-on flag itself stays clear. Software reads the register through a single-cycle register port, and writing a 0 to a flag clears it. A parameter selects whether the read data is combinational or registered with one cycle of latency.

Top module: `reset_cause_reg`

## Requirements
- R1: After a cycle with `por` high the register reads 0x0000_0002 (only bit 1, the power-on flag, set), even if source events arrive in that same cycle.
- R2: Asserting `rst` leaves every flag unchanged; only `por` alters the stored flags without an event or a write.
- R3: Each qualified event sets its own bit: external pin bit 0, brown-out bit 2, watchdog 0 bit 3, software bit 4, watchdog 1 bit 5, hibernation-sequence bit 12, oscillator failure bit 16. Flags accumulate across cycles, and events in the same cycle are ORed together.
- R4: A write to byte address 0x05C clears every flag whose `bus_wdata` bit is 0 and leaves unchanged every flag whose bit is 1.
- R5: When an event and a clearing write hit the same flag in the same cycle, the flag ends set.
- R6: Bits 6 to 11, 13 to 15 and 17 to 31 always read 0, including after writes of 1.
- R7: An event from the external pin, brown-out, watchdog 0 or watchdog 1 whose behaviour field is 2'b11 clears all earlier flags and records only that cycle's events; bit 1 stays clear. Under the other field codes (2'b00, 2'b01, 2'b10) the events just accumulate.
- R8: `mosc_fail` sets bit 16 only when `mosc_chk_en` is 1 and `mosc_int_mode` is 0.
- R9: Reads at any other address return 0, and writes at any other address have no effect.
- R10: With READ_REG = 0, `bus_rdata` follows the flags in the same cycle. With READ_REG = 1, it shows the flags that were present at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Ordinary synchronous reset; clears only the registered read data |
| por | input | 1 | True power-on, synchronous, active high |
| ev_ext | input | 1 | External pin reset event pulse |
| ev_bor | input | 1 | Brown-out reset event pulse |
| ev_wdt0 | input | 1 | Watchdog 0 reset event pulse |
| ev_wdt1 | input | 1 | Watchdog 1 reset event pulse |
| ev_sw | input | 1 | Software reset request pulse |
| ev_hssr | input | 1 | Hibernation-sequence reset pulse |
| mosc_fail | input | 1 | Main-oscillator failure pulse |
| mosc_chk_en | input | 1 | Oscillator clock validation enabled |
| mosc_int_mode | input | 1 | Oscillator failure raises an interrupt instead of a reset |
| beh_ext | input | 2 | Behaviour field for the external pin; 2'b11 selects simulated power-on |
| beh_bor | input | 2 | Behaviour field for brown-out |
| beh_wdt0 | input | 2 | Behaviour field for watchdog 0 |
| beh_wdt1 | input | 2 | Behaviour field for watchdog 1 |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |

## Verification
The bench builds two instances side by side and drives them with the same inputs: `dut` uses READ_REG = 1 and `dut_comb` uses READ_REG = 0, both with a 12-bit address. Running both variants on every stimulus exposes any difference between the registered and combinational read paths. It also allows a directed check of the one-cycle lag, in which the two outputs are seen to differ for exactly one cycle after a flag changes.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_SRC = 7;

    // Flag positions (software decodes these)
    localparam int B_EXT  = 0;
    localparam int B_POR  = 1;
    localparam int B_BOR  = 2;
    localparam int B_WDT0 = 3;
    localparam int B_SW   = 4;
    localparam int B_WDT1 = 5;
    localparam int B_HSSR = 12;
    localparam int B_MOSC = 16;

    localparam logic [1:0] BEH_SIM_POR = 2'b11;

    typedef enum logic [2:0] {
        SRC_EXT  = 3'd0,
        SRC_BOR  = 3'd1,
        SRC_WDT0 = 3'd2,
        SRC_SW   = 3'd3,
        SRC_WDT1 = 3'd4,
        SRC_HSSR = 3'd5,
        SRC_MOSC = 3'd6
    } src_e;

    typedef struct packed {
        logic mosc_fail;
        logic hssr;
        logic wdt1;
        logic sw;
        logic wdt0;
        logic bor;
        logic ext;
    } src_pulse_t;

    typedef struct packed {
        logic [1:0] ext;
        logic [1:0] bor;
        logic [1:0] wdt0;
        logic [1:0] wdt1;
    } beh_cfg_t;

    typedef struct packed {
        logic chk_en;
        logic int_mode;
    } mosc_ctl_t;

    function automatic int src_bit(input int idx);
        case (idx)
            0:       return B_EXT;
            1:       return B_BOR;
            2:       return B_WDT0;
            3:       return B_SW;
            4:       return B_WDT1;
            5:       return B_HSSR;
            default: return B_MOSC;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] impl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        m[B_POR] = 1'b1;
        for (int i = 0; i < NUM_SRC; i++) m[src_bit(i)] = 1'b1;
        return m;
    endfunction

    function automatic logic is_sim_por(input logic [1:0] field);
        return field == BEH_SIM_POR;
    endfunction

    localparam logic [DATA_W-1:0] IMPL_MASK = impl_mask();
    localparam logic [DATA_W-1:0] POR_VALUE = DATA_W'(1) << B_POR;

endpackage

// File: rtl/rstc_event_qual.sv
module rstc_event_qual
    import rstc_pkg::*;
(
    input  src_pulse_t          pulses,
    input  beh_cfg_t            beh,
    input  mosc_ctl_t           mosc,
    output logic [DATA_W-1:0]   set_vec,
    output logic                sim_any
);
    logic [NUM_SRC-1:0] raw;
    logic [NUM_SRC-1:0] qual;
    logic [NUM_SRC-1:0] sim_cap;

    assign raw = pulses;

    // Only some sources carry a behaviour field
    assign sim_cap[SRC_EXT]  = is_sim_por(beh.ext);
    assign sim_cap[SRC_BOR]  = is_sim_por(beh.bor);
    assign sim_cap[SRC_WDT0] = is_sim_por(beh.wdt0);
    assign sim_cap[SRC_WDT1] = is_sim_por(beh.wdt1);
    assign sim_cap[SRC_SW]   = 1'b0;
    assign sim_cap[SRC_HSSR] = 1'b0;
    assign sim_cap[SRC_MOSC] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_qual
            if (gi == int'(SRC_MOSC)) begin : g_osc
                // counts only when the failure really produced a reset
                assign qual[gi] = raw[gi] & mosc.chk_en & ~mosc.int_mode;
            end else begin : g_plain
                assign qual[gi] = raw[gi];
            end
        end
    endgenerate

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NUM_SRC; i++) set_vec[src_bit(i)] = qual[i];
    end

    assign sim_any = |(qual & sim_cap);

endmodule

// File: rtl/rstc_flag_store.sv
module rstc_flag_store
    import rstc_pkg::*;
(
    input  logic                clk,
    input  logic                por,
    input  logic [DATA_W-1:0]   set_vec,
    input  logic                sim_any,
    input  logic                wr_hit,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   flags
);
    logic [DATA_W-1:0] flags_q;
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] flags_d;

    always_comb begin
        base    = sim_any ? '0 : flags_q;       // simulated power-on wipes history
        keep    = wr_hit ? wdata : '1;          // zero clears, one keeps
        flags_d = ((base & keep) | set_vec) & IMPL_MASK;   // set beats clear
    end

    always_ff @(posedge clk) begin
        if (por) flags_q <= POR_VALUE;
        else     flags_q <= flags_d;
    end

    assign flags = flags_q;

endmodule

// File: rtl/rstc_bus_port.sv
module rstc_bus_port
    import rstc_pkg::*;
#(
    parameter int               ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] OFFSET  = ADDR_W'(12'h05C),
    parameter bit               READ_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    input  logic [DATA_W-1:0]   flags,
    output logic                rd_hit,
    output logic                wr_hit,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] rd_mux;

    assign rd_hit = (addr == OFFSET);
    assign wr_hit = rd_hit & we;
    assign rd_mux = rd_hit ? flags : '0;

    generate
        if (READ_REG) begin : g_rd_reg
            logic [DATA_W-1:0] rdata_q;
            always_ff @(posedge clk) begin
                if (rst) rdata_q <= '0;
                else     rdata_q <= rd_mux;
            end
            assign rdata = rdata_q;
        end else begin : g_rd_comb
            assign rdata = rd_mux;
        end
    endgenerate

endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
    import rstc_pkg::*;
#(
    parameter int               ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] OFFSET  = ADDR_W'(12'h05C),
    parameter bit               READ_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                por,
    input  logic                ev_ext,
    input  logic                ev_bor,
    input  logic                ev_wdt0,
    input  logic                ev_wdt1,
    input  logic                ev_sw,
    input  logic                ev_hssr,
    input  logic                mosc_fail,
    input  logic                mosc_chk_en,
    input  logic                mosc_int_mode,
    input  logic [1:0]          beh_ext,
    input  logic [1:0]          beh_bor,
    input  logic [1:0]          beh_wdt0,
    input  logic [1:0]          beh_wdt1,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata
);
    src_pulse_t         pulses;
    beh_cfg_t           beh;
    mosc_ctl_t          mosc;
    logic [DATA_W-1:0]  set_vec;
    logic               sim_any;
    logic               rd_hit;
    logic               wr_hit;
    logic [DATA_W-1:0]  flags;

    assign pulses = '{mosc_fail: mosc_fail, hssr: ev_hssr, wdt1: ev_wdt1,
                      sw: ev_sw, wdt0: ev_wdt0, bor: ev_bor, ext: ev_ext};
    assign beh    = '{ext: beh_ext, bor: beh_bor, wdt0: beh_wdt0, wdt1: beh_wdt1};
    assign mosc   = '{chk_en: mosc_chk_en, int_mode: mosc_int_mode};

    rstc_event_qual u_qual (
        .pulses  (pulses),
        .beh     (beh),
        .mosc    (mosc),
        .set_vec (set_vec),
        .sim_any (sim_any)
    );

    rstc_bus_port #(
        .ADDR_W   (ADDR_W),
        .OFFSET   (OFFSET),
        .READ_REG (READ_REG)
    ) u_bus (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .we     (bus_we),
        .flags  (flags),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit),
        .rdata  (bus_rdata)
    );

    rstc_flag_store u_store (
        .clk     (clk),
        .por     (por),
        .set_vec (set_vec),
        .sim_any (sim_any),
        .wr_hit  (wr_hit),
        .wdata   (bus_wdata),
        .flags   (flags)
    );

endmodule

// File: rtl/rstc_checker.sv
module rstc_checker
    import rstc_pkg::*;
#(
    parameter bit READ_REG = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic                por,
    input logic                mosc_fail,
    input logic                mosc_chk_en,
    input logic                mosc_int_mode,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [DATA_W-1:0]   flags,
    input logic [DATA_W-1:0]   set_vec,
    input logic                sim_any,
    input logic                rd_hit,
    input logic                wr_hit
);
    // R1: power-on forces the one-hot power-on value
    p_por_value_r1: assert property (@(posedge clk) por |=> (flags == POR_VALUE || por));

    // R2: ordinary reset with no event or write keeps the flags
    p_sticky_r2: assert property (@(posedge clk) disable iff (por)
        (rst && set_vec == '0 && !wr_hit) |=> flags == $past(flags));

    // R4: write-zero-to-clear, write-one-keeps
    p_clear_r4: assert property (@(posedge clk) disable iff (por)
        (wr_hit && set_vec == '0) |=> flags == ($past(flags) & $past(bus_wdata)));

    // R5: every raised event is present next cycle
    p_set_wins_r5: assert property (@(posedge clk) disable iff (por)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R7: only a true power-on raises bit 1; simulated power-on keeps just new causes
    p_no_por_bit_r7: assert property (@(posedge clk) disable iff (por)
        !flags[B_POR] |=> !flags[B_POR]);
    p_sim_wipe_r7: assert property (@(posedge clk) disable iff (por)
        sim_any |=> flags == $past(set_vec));

    // R8: a disqualified oscillator failure leaves bit 16 alone
    p_mosc_gate_r8: assert property (@(posedge clk) disable iff (por)
        (mosc_fail && (!mosc_chk_en || mosc_int_mode) && !wr_hit && !sim_any)
        |=> flags[B_MOSC] == $past(flags[B_MOSC]));

    // R10: read latency per variant
    generate
        if (READ_REG) begin : g_lat_reg
            p_rd_latency_r10: assert property (@(posedge clk) disable iff (por || rst)
                rd_hit |=> bus_rdata == $past(flags));
        end else begin : g_lat_comb
            p_rd_latency_r10: assert property (@(posedge clk) disable iff (por)
                rd_hit |-> bus_rdata == flags);
        end
    endgenerate

endmodule

bind reset_cause_reg rstc_checker #(.READ_REG(READ_REG)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .por           (por),
    .mosc_fail     (mosc_fail),
    .mosc_chk_en   (mosc_chk_en),
    .mosc_int_mode (mosc_int_mode),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .flags         (flags),
    .set_vec       (set_vec),
    .sim_any       (sim_any),
    .rd_hit        (rd_hit),
    .wr_hit        (wr_hit)
);

// File: tb/tb_reset_cause_reg.sv
`timescale 1ns/1ps
module tb_reset_cause_reg;

    localparam int          AW    = 12;
    localparam logic [11:0] A_REG = 12'h05C;
    localparam int          VW    = 7 + 2 + 1 + 32 + 32;
    localparam int          NV    = 15;

    // {ev[6:0] = mosc,hssr,wdt1,sw,wdt0,bor,ext ; beh ; we ; wdata ; expected}
    localparam logic [VW-1:0] VEC [NV] = '{
        {7'b0000000, 2'b00, 1'b0, 32'h0,         32'h0000_0002},  // R1 idle
        {7'b0000001, 2'b00, 1'b0, 32'h0,         32'h0000_0003},  // R3 ext
        {7'b0000110, 2'b00, 1'b0, 32'h0,         32'h0000_000F},  // R3 bor+wdt0
        {7'b0000000, 2'b00, 1'b1, 32'hFFFF_FFFF, 32'h0000_000F},  // R4/R6 ones keep
        {7'b0000000, 2'b00, 1'b1, 32'hFFFF_FFFE, 32'h0000_000E},  // R4 clear bit 0
        {7'b0111000, 2'b00, 1'b0, 32'h0,         32'h0000_103E},  // R3 sw,wdt1,hssr
        {7'b1000000, 2'b00, 1'b0, 32'h0,         32'h0001_103E},  // R8 osc qualified
        {7'b0000000, 2'b00, 1'b1, 32'h0,         32'h0000_0000},  // R4 clear all
        {7'b0000001, 2'b00, 1'b1, 32'h0,         32'h0000_0001},  // R5 set wins
        {7'b0000100, 2'b11, 1'b0, 32'h0,         32'h0000_0008},  // R7 sim wdt0
        {7'b0000011, 2'b11, 1'b0, 32'h0,         32'h0000_0005},  // R7 sim bor+ext
        {7'b0001000, 2'b11, 1'b0, 32'h0,         32'h0000_0015},  // R7 sw not sim
        {7'b0000000, 2'b00, 1'b1, 32'h0,         32'h0000_0000},  // R4 clear
        {7'b0010000, 2'b10, 1'b0, 32'h0,         32'h0000_0020},  // R7 code 10
        {7'b0000001, 2'b01, 1'b0, 32'h0,         32'h0000_0021}   // R7 code 01
    };

    logic clk = 1'b0;
    logic rst, por;
    logic ev_ext, ev_bor, ev_wdt0, ev_wdt1, ev_sw, ev_hssr, mosc_fail;
    logic mosc_chk_en, mosc_int_mode;
    logic [1:0] beh;
    logic [AW-1:0] bus_addr;
    logic bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] rdata_r, rdata_c;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    reset_cause_reg #(.ADDR_W(AW), .OFFSET(A_REG), .READ_REG(1'b1)) dut (
        .clk(clk), .rst(rst), .por(por),
        .ev_ext(ev_ext), .ev_bor(ev_bor), .ev_wdt0(ev_wdt0), .ev_wdt1(ev_wdt1),
        .ev_sw(ev_sw), .ev_hssr(ev_hssr), .mosc_fail(mosc_fail),
        .mosc_chk_en(mosc_chk_en), .mosc_int_mode(mosc_int_mode),
        .beh_ext(beh), .beh_bor(beh), .beh_wdt0(beh), .beh_wdt1(beh),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_r)
    );

    reset_cause_reg #(.ADDR_W(AW), .OFFSET(A_REG), .READ_REG(1'b0)) dut_comb (
        .clk(clk), .rst(rst), .por(por),
        .ev_ext(ev_ext), .ev_bor(ev_bor), .ev_wdt0(ev_wdt0), .ev_wdt1(ev_wdt1),
        .ev_sw(ev_sw), .ev_hssr(ev_hssr), .mosc_fail(mosc_fail),
        .mosc_chk_en(mosc_chk_en), .mosc_int_mode(mosc_int_mode),
        .beh_ext(beh), .beh_bor(beh), .beh_wdt0(beh), .beh_wdt1(beh),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_c)
    );

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ev(input logic [6:0] e);
        {mosc_fail, ev_hssr, ev_wdt1, ev_sw, ev_wdt0, ev_bor, ev_ext} = e;
    endtask

    // one edge to let registered read catch up, then compare both variants
    task automatic read_both(input logic [31:0] exp, input string req);
        @(posedge clk);
        @(negedge clk);
        cmp(rdata_r, exp, req);
        cmp(rdata_c, exp, req);
    endtask

    task automatic apply(input logic [6:0] e, input logic [1:0] b,
                         input logic we, input logic [31:0] wd);
        @(negedge clk);
        set_ev(e); beh = b; bus_we = we; bus_wdata = wd;
        @(negedge clk);
        set_ev(7'b0); beh = 2'b00; bus_we = 1'b0; bus_wdata = '0;
    endtask

    initial begin
        rst = 1'b1; por = 1'b1;
        set_ev(7'b0); mosc_chk_en = 1'b1; mosc_int_mode = 1'b0;
        beh = 2'b00; bus_addr = A_REG; bus_we = 1'b0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        por = 1'b0; rst = 1'b0;
        read_both(32'h2, "R1 reset state");

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][73:67], VEC[i][66:65], VEC[i][64], VEC[i][63:32]);
            read_both(VEC[i][31:0], $sformatf("R3/R4/R5/R6/R7 vector %0d", i));
        end

        // R2: ordinary reset keeps flags (0x21)
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        read_both(32'h21, "R2 sticky over rst");

        // R8: disqualified oscillator failures
        mosc_chk_en = 1'b0;
        apply(7'b1000000, 2'b00, 1'b0, '0);
        read_both(32'h21, "R8 validation off");
        mosc_chk_en = 1'b1; mosc_int_mode = 1'b1;
        apply(7'b1000000, 2'b00, 1'b0, '0);
        read_both(32'h21, "R8 interrupt mode");
        mosc_int_mode = 1'b0;

        // R9: wrong address write ignored, wrong address read is zero
        bus_addr = 12'h060;
        apply(7'b0, 2'b00, 1'b1, 32'h0);
        read_both(32'h0, "R9 other address reads zero");
        bus_addr = A_REG;
        read_both(32'h21, "R9 other address write ignored");

        // R10: registered read lags combinational by one cycle
        @(negedge clk); ev_hssr = 1'b1;
        @(negedge clk); ev_hssr = 1'b0;
        cmp(rdata_c, 32'h1021, "R10 comb same cycle");
        cmp(rdata_r, 32'h21,   "R10 reg still old");
        @(negedge clk);
        cmp(rdata_r, 32'h1021, "R10 reg one cycle later");

        // R1: power-on beats simultaneous events
        @(negedge clk); por = 1'b1; set_ev(7'b0111111);
        @(negedge clk); por = 1'b0; set_ev(7'b0);
        read_both(32'h2, "R1 por over events");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule